// File: doc/BRIEF.md
# Windowed Watchdog Timer with Restart Key

This block is a watchdog counter that runs on a slow clock and asks for a system reset unless software restarts it in time. A 3-bit select input chooses the overflow period from a fixed set of power-of-two cycle counts. Software restarts the counter by writing one key byte, 0xAC, through a write strobe and data bus.

The window mode is fixed at 75% open. The second quarter of each period, starting at half the period, is a forbidden zone. A key write that falls inside it is treated as a fault, and so is a write of any other byte. A flag rises at three quarters of the period to tell software that a restart is allowed again. Software clears the flag with a one-cycle pulse.

Top module: `wwdt_top`

## Requirements
- R1: The period T in clock cycles is 2^E, where E depends on `sel_i`: 0→6, 1→7, 2→8, 3→9, 4→11, 5→13, 6→14, 7→16.
- R2: If no write occurs, `wdt_rst_o` is high for exactly one cycle, and this happens T cycles after the counter last restarted from zero.
- R3: A write of 0xAC while the count is below T/2, or at or above 3T/4, returns the count to zero, clears `irq_flag_o` and raises no reset request.
- R4: A write of 0xAC while the count is at least T/2 and below 3T/4 raises `wdt_rst_o` in the next cycle.
- R5: A write of any byte other than 0xAC, at any count, raises `wdt_rst_o` in the next cycle.
- R6: `irq_flag_o` goes high in the same cycle that the count reaches 3T/4.
- R7: A high `flag_clr_i` clears `irq_flag_o`. If the flag is being set in the same cycle, the set takes effect.
- R8: Every reset request restarts the count from zero and clears `irq_flag_o`, so the next overflow comes a full T cycles later.
- R9: While `rst_ni` is low, `wdt_rst_o` and `irq_flag_o` are low and the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow counting clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Overflow period select |
| wr_en_i | input | 1 | Write strobe for the key register |
| wr_data_i | input | 8 | Byte written to the key register |
| flag_clr_i | input | 1 | Clears the interval flag |
| wdt_rst_o | output | 1 | One-cycle reset request |
| irq_flag_o | output | 1 | Interval flag: a restart is allowed |

## Verification
The hardest cases to reach are key writes that land exactly on the window edges: counts T/2 and 3T/4−1, which must fault, and 3T/4, which must not. Another is a flag clear that arrives in the same cycle as the flag set. The stimulus first sends a bad key, which puts the count at zero at a known clock edge. It then waits an exact number of cycles before it drives the write, so every boundary is hit on purpose. The long periods, up to 65536 cycles, are each run through in full once.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned KEY_W = 8;

  // period exponent per select code; 10, 12 and 15 are not offered
  function automatic int unsigned sel_exp(logic [2:0] sel);
    case (sel)
      3'd0: return 6;
      3'd1: return 7;
      3'd2: return 8;
      3'd3: return 9;
      3'd4: return 11;
      3'd5: return 13;
      3'd6: return 14;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/wwdt_period_dec.sv
module wwdt_period_dec #(
  parameter int unsigned CNT_W = wwdt_pkg::CNT_W
) (
  input  logic [2:0]       sel_i,
  output logic [CNT_W-1:0] last_o,
  output logic [CNT_W-1:0] win_lo_o,
  output logic [CNT_W-1:0] win_hi_o
);
  localparam int unsigned PW = CNT_W + 1;

  logic [PW-1:0] period;

  always_comb begin
    period   = PW'(1) << wwdt_pkg::sel_exp(sel_i);
    last_o   = CNT_W'(period - PW'(1));
    win_lo_o = CNT_W'(period >> 1);
    win_hi_o = CNT_W'((period >> 1) + (period >> 2));
  end
endmodule

// File: rtl/wwdt_key_chk.sv
module wwdt_key_chk #(
  parameter int unsigned CNT_W = wwdt_pkg::CNT_W,
  parameter int unsigned KEY_W = wwdt_pkg::KEY_W,
  parameter logic [KEY_W-1:0] KEY = 8'hAC
) (
  input  logic             wr_en_i,
  input  logic [KEY_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] win_lo_i,
  input  logic [CNT_W-1:0] win_hi_i,
  output logic             clr_ok_o,
  output logic             viol_o
);
  logic key_match, in_window;

  assign key_match = (wr_data_i == KEY);
  assign in_window = (cnt_i >= win_lo_i) && (cnt_i < win_hi_i);
  assign clr_ok_o  = wr_en_i && key_match && !in_window;
  assign viol_o    = wr_en_i && (!key_match || in_window);
endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter #(
  parameter int unsigned CNT_W = wwdt_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] last_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  // any write restarts: a valid clear or a fault
  assign ovf_o      = !wr_i && (cnt_q >= last_i);
  assign cnt_next_o = (wr_i || ovf_o) ? '0 : cnt_q + CNT_W'(1);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_next_o;
  end
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top #(
  parameter int unsigned CNT_W = wwdt_pkg::CNT_W,
  parameter int unsigned KEY_W = wwdt_pkg::KEY_W,
  parameter logic [KEY_W-1:0] KEY = 8'hAC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       sel_i,
  input  logic             wr_en_i,
  input  logic [KEY_W-1:0] wr_data_i,
  input  logic             flag_clr_i,
  output logic             wdt_rst_o,
  output logic             irq_flag_o
);
  logic [CNT_W-1:0] last_cnt, win_lo, win_hi, cnt_q, cnt_next;
  logic clr_ok, viol, ovf, restart;
  logic rst_q, flag_q;

  wwdt_period_dec #(.CNT_W(CNT_W)) dec_i (
    .sel_i    (sel_i),
    .last_o   (last_cnt),
    .win_lo_o (win_lo),
    .win_hi_o (win_hi)
  );

  wwdt_key_chk #(.CNT_W(CNT_W), .KEY_W(KEY_W), .KEY(KEY)) key_i (
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cnt_i     (cnt_q),
    .win_lo_i  (win_lo),
    .win_hi_i  (win_hi),
    .clr_ok_o  (clr_ok),
    .viol_o    (viol)
  );

  wwdt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_en_i),
    .last_i     (last_cnt),
    .cnt_o      (cnt_q),
    .cnt_next_o (cnt_next),
    .ovf_o      (ovf)
  );

  assign restart = clr_ok || viol || ovf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      rst_q <= viol || ovf;
      if (restart)                 flag_q <= 1'b0;
      else if (cnt_next == win_hi) flag_q <= 1'b1;  // set beats clear
      else if (flag_clr_i)         flag_q <= 1'b0;
    end
  end

  assign wdt_rst_o  = rst_q;
  assign irq_flag_o = flag_q;
endmodule

// File: rtl/wwdt_chk.sv
module wwdt_chk #(
  parameter int unsigned CNT_W = wwdt_pkg::CNT_W,
  parameter int unsigned KEY_W = wwdt_pkg::KEY_W,
  parameter logic [KEY_W-1:0] KEY = 8'hAC
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [KEY_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] last_cnt,
  input logic [CNT_W-1:0] win_lo,
  input logic [CNT_W-1:0] win_hi,
  input logic             wdt_rst_o,
  input logic             irq_flag_o
);
  // R2
  overflow_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && cnt_q == last_cnt) |=> (wdt_rst_o && cnt_q == '0));

  // R3
  good_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i == KEY && (cnt_q < win_lo || cnt_q >= win_hi))
      |=> (!wdt_rst_o && !irq_flag_o && cnt_q == '0));

  // R4
  window_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && cnt_q >= win_lo && cnt_q < win_hi) |=> wdt_rst_o);

  // R5
  bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i != KEY) |=> wdt_rst_o);

  // R6
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && cnt_q + CNT_W'(1) == win_hi && cnt_q < last_cnt) |=> irq_flag_o);

  // R8
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> (cnt_q == '0 && !irq_flag_o));
endmodule

bind wwdt_top wwdt_chk #(.CNT_W(CNT_W), .KEY_W(KEY_W), .KEY(KEY)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .cnt_q      (cnt_q),
  .last_cnt   (last_cnt),
  .win_lo     (win_lo),
  .win_hi     (win_hi),
  .wdt_rst_o  (wdt_rst_o),
  .irq_flag_o (irq_flag_o)
);

// File: tb/wwdt_top_tb.sv
`timescale 1ns/1ps
module wwdt_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       fclr = 1'b0;
  logic       rst_o, flag_o;

  int n_chk = 0, n_err = 0;
  int m_cnt = 0;
  bit m_rst = 0, m_flag = 0;

  always #2.5 clk = ~clk;

  wwdt_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_en_i(wr),
    .wr_data_i(wdata), .flag_clr_i(fclr), .wdt_rst_o(rst_o), .irq_flag_o(flag_o)
  );

  function automatic int period_of(logic [2:0] s);
    int e[8] = '{6, 7, 8, 9, 11, 13, 14, 16};
    return 1 << e[s];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference, updated on every edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_rst = 0; m_flag = 0;
    end else begin
      int t;
      bit fault, restart;
      t = period_of(sel);
      fault = 0; restart = 0;
      if (wr) begin
        restart = 1;
        if (wdata != 8'hAC || (m_cnt >= t / 2 && m_cnt < 3 * t / 4)) fault = 1;
      end else if (m_cnt >= t - 1) begin
        restart = 1; fault = 1;
      end
      m_rst = fault;
      if (restart) begin
        m_cnt = 0; m_flag = 0;
      end else begin
        m_cnt++;
        if (m_cnt == 3 * t / 4) m_flag = 1;
        else if (fclr) m_flag = 0;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(rst_o == m_rst, "R2 per-cycle reset request", rst_o, m_rst);
    chk(flag_o == m_flag, "R6 per-cycle interval flag", flag_o, m_flag);
  end

  // fault write: leaves the count at zero at the returning negedge
  task automatic kick_bad();
    @(negedge clk); wr = 1; wdata = 8'h55;
    @(negedge clk); wr = 0;
  endtask

  task automatic measure(logic [2:0] s, string req);
    int n = 0;
    kick_bad();
    sel = s;
    do begin @(negedge clk); n++; end while (!rst_o && n < 70000);
    chk(n == period_of(s), req, n, period_of(s));
  endtask

  // write at count n, return with outcome visible
  task automatic write_at(int n, logic [7:0] d);
    kick_bad();
    repeat (n) @(negedge clk);
    wr = 1; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #1;
    chk(rst_o == 0 && flag_o == 0, "R9 reset state", {rst_o, flag_o}, 0);
    #11 rst_n = 1;
    @(negedge clk);
    chk(rst_o == 0 && flag_o == 0, "R9 idle after release", {rst_o, flag_o}, 0);

    for (int s = 0; s < 8; s++) measure(3'(s), "R1 R2 overflow period");
    kick_bad();
    chk(rst_o == 1, "R5 bad key 0x55 faults", rst_o, 1);
    measure(3'd0, "R8 full period after fault");

    sel = 3'd0;
    write_at(31, 8'hAC); chk(rst_o == 0, "R3 clear at 31 allowed", rst_o, 0);
    write_at(32, 8'hAC); chk(rst_o == 1, "R4 clear at T/2 faults", rst_o, 1);
    write_at(47, 8'hAC); chk(rst_o == 1, "R4 clear at 3T/4-1 faults", rst_o, 1);
    kick_bad(); repeat (48) @(negedge clk);
    chk(flag_o == 1, "R6 flag at 3T/4", flag_o, 1);
    wr = 1; wdata = 8'hAC; @(negedge clk); wr = 0;
    chk(rst_o == 0 && flag_o == 0, "R3 clear at 3T/4 ok, flag cleared", {rst_o, flag_o}, 0);
    write_at(5, 8'hAD); chk(rst_o == 1, "R5 wrong key early", rst_o, 1);
    write_at(60, 8'h00); chk(rst_o == 1, "R5 wrong key late", rst_o, 1);

    kick_bad(); repeat (47) @(negedge clk);
    fclr = 1; @(negedge clk); fclr = 0;
    chk(flag_o == 1, "R7 set wins over clear", flag_o, 1);
    fclr = 1; @(negedge clk); fclr = 0;
    chk(flag_o == 0, "R7 clear pulse", flag_o, 0);

    sel = 3'd4;
    write_at(1023, 8'hAC); chk(rst_o == 0, "R3 T=2048 before window", rst_o, 0);
    write_at(1024, 8'hAC); chk(rst_o == 1, "R4 T=2048 window start", rst_o, 1);
    write_at(1536, 8'hAC); chk(rst_o == 0, "R3 T=2048 after window", rst_o, 0);

    rst_n = 0; #1;
    chk(rst_o == 0 && flag_o == 0, "R9 async reset", {rst_o, flag_o}, 0);
    @(negedge clk); rst_n = 1;
    measure(3'd0, "R9 count zero after reset");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule